// File: doc/BRIEF.md
# Multiport Transmit Packet FIFO Writer

This block takes packet words from a host bus and files each one into one of up to eight per-port transmit queues. The host drives an active-low select, a port number, a 64-bit data word, active-low byte enables, first-word and last-word markers, and one shared qualifier flag. The flag has two meanings. With the first word of a packet it asks that the packet be sent with no padding and no CRC added. With the last word it asks that the packet be sent with a forced error.

Each stored entry holds the data, the lowest valid byte lane, the number of valid bytes, the first/last markers and three per-packet tags for the downstream MAC: skip padding and CRC, force error, and "the previous packet on this port was cut short". The block rejects illegal byte-enable patterns, words that arrive outside a packet, and writes to a full queue, and it records each rejection in sticky per-port flags. A simple read port lets the MAC pull one entry from any queue, and the entry appears one cycle after the request. A narrow-bus input limits the block to the lower four byte lanes.

Top module: `txpkt_fifo_writer`

## Requirements
- R1: While `wr_sel_n` is high, nothing is written to any queue, whatever the other write inputs carry.
- R2: A written word goes to the queue numbered by `wr_port`, and each queue returns its words in arrival order together with their `rd_sop`/`rd_eop` markers.
- R3: Active-high enables are `~wr_be_n`, and bit n covers data bits [8n+7:8n]. A write with no enabled byte, or with enabled bytes that do not form one contiguous run, is not stored and sets `proto_err[wr_port]`, which stays set until reset. A stored entry reports the lowest enabled lane on `rd_lane` and the count of enabled bytes on `rd_nbytes`.
- R4: When `wr_flag` is high on a first word, every word of that packet reads back with `rd_no_pad_crc`=1. When it is low, every word reads back with `rd_no_pad_crc`=0.
- R5: `rd_force_err` is 1 exactly on a last word that was written with `wr_flag` high.
- R6: A first word written to a port that still has an open packet is stored with `rd_prev_abort`=1 and starts a new packet. All other words read back with `rd_prev_abort`=0.
- R7: A word without `wr_sop` written to a port with no open packet is not stored and sets `proto_err` for that port.
- R8: Each queue holds 16 entries. A legal write to a full queue is dropped, even if the same queue is read in that cycle, and it sets `overflow` for that port, which stays set until reset.
- R9: While `narrow_mode` is 1, enables 7:4 count as disabled and data bits 63:32 are stored as zero.
- R10: When `rd_en` is high and the queue at `rd_port` is not empty, the next cycle shows `rd_valid`=1 with that queue's oldest entry. Otherwise the next cycle shows `rd_valid`=0.
- R11: After reset, all queues are empty, no queue is full, every flag is clear and `rd_valid` is 0.
- R12: `fifo_empty` and `fifo_full` reflect each queue's occupancy in the cycle after the write or read that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_sel_n | input | 1 | Active-low write select |
| wr_port | input | 3 | Target queue of the write |
| wr_data | input | 64 | Write data |
| wr_be_n | input | 8 | Active-low byte enables |
| wr_sop | input | 1 | First word of a packet |
| wr_eop | input | 1 | Last word of a packet |
| wr_flag | input | 1 | Skip padding/CRC on the first word; force error on the last word |
| narrow_mode | input | 1 | Use only the lower 32 bits and enables 3:0 |
| rd_en | input | 1 | Read request |
| rd_port | input | 3 | Queue to read |
| rd_valid | output | 1 | Read result is valid this cycle |
| rd_data | output | 64 | Read data |
| rd_lane | output | 3 | Lowest valid byte lane |
| rd_nbytes | output | 4 | Number of valid bytes |
| rd_sop | output | 1 | Entry is a first word |
| rd_eop | output | 1 | Entry is a last word |
| rd_no_pad_crc | output | 1 | Packet must be sent without padding or CRC |
| rd_force_err | output | 1 | Packet must end with a forced error |
| rd_prev_abort | output | 1 | Previous packet on this port was cut short |
| fifo_empty | output | 8 | Per-queue empty |
| fifo_full | output | 8 | Per-queue full |
| proto_err | output | 8 | Sticky per-queue protocol error |
| overflow | output | 8 | Sticky per-queue overflow |

## Verification
The assertions assume that `rst` is high for the first clock edge and that the select, port, marker and flag inputs never carry X or Z while reset is low. Under those conditions every write is either stored or counted as rejected. The byte-enable checks also assume that `narrow_mode` changes only between words. The stimulus drives every input at the falling clock edge, holds reset over the first edges, and changes `narrow_mode` only together with the word it qualifies. Its randomized phase builds enables mainly from a start lane plus a length, and it adds occasional arbitrary patterns so that rejections also occur.

// File: rtl/txw_pkg.sv
package txw_pkg;

  typedef struct packed {
    logic sop;
    logic eop;
    logic no_pad_crc;
    logic force_err;
    logic prev_abort;
  } txw_tag_t;

endpackage

// File: rtl/txw_be_check.sv
module txw_be_check #(
  parameter int LANES  = 8,
  parameter int LANE_W = 3,
  parameter int NB_W   = 4
) (
  input  logic [LANES-1:0]  be_n,
  input  logic              narrow,
  output logic              legal,
  output logic [LANE_W-1:0] first_lane,
  output logic [NB_W-1:0]   nbytes
);

  logic [LANES-1:0] be_act;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      be_act[i] = ~be_n[i] & ~(narrow & (i >= LANES / 2));
    end
  end

  always_comb begin
    int lo;
    int hi;
    int cnt;
    lo  = 0;
    hi  = 0;
    cnt = 0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (be_act[i]) lo = i;
    end
    for (int i = 0; i < LANES; i++) begin
      if (be_act[i]) begin
        hi  = i;
        cnt = cnt + 1;
      end
    end
    legal      = (cnt != 0) && ((hi - lo + 1) == cnt);
    first_lane = LANE_W'(lo);
    nbytes     = NB_W'(cnt);
  end

endmodule

// File: rtl/txw_port_ctrl.sv
module txw_port_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic             legal,
  input  logic             sop,
  input  logic             eop,
  input  logic             flag,
  output logic             accept,
  output logic             abort_tag,
  output logic             raw_tag,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic             empty,
  output logic             full,
  output logic             proto_err,
  output logic             overflow
);

  logic [CNT_W-1:0] cnt_q;
  logic             open_q;
  logic             raw_q;
  logic             take;
  logic             bad_proto;

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign bad_proto = wr_hit && (!legal || (!sop && !open_q));
  assign accept    = wr_hit && !bad_proto && !full;
  assign take      = rd_hit && !empty;
  assign abort_tag = sop && open_q;
  assign raw_tag   = sop ? flag : raw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      wptr      <= '0;
      rptr      <= '0;
      open_q    <= 1'b0;
      raw_q     <= 1'b0;
      proto_err <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (accept) begin
        wptr   <= wptr + 1'b1;
        open_q <= !eop;
        if (sop) raw_q <= flag;
      end
      if (take) rptr <= rptr + 1'b1;
      cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(take);
      if (bad_proto) proto_err <= 1'b1;
      else if (wr_hit && full) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/txw_store.sv
module txw_store #(
  parameter int ADDR_W = 7,
  parameter int W      = 76
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);

  localparam int ENTRIES = 1 << ADDR_W;

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/txpkt_fifo_writer.sv
module txpkt_fifo_writer
  import txw_pkg::*;
#(
  parameter int PSEL_W = 3,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_sel_n,
  input  logic [PSEL_W-1:0]          wr_port,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [DATA_W/8-1:0]        wr_be_n,
  input  logic                       wr_sop,
  input  logic                       wr_eop,
  input  logic                       wr_flag,
  input  logic                       narrow_mode,
  input  logic                       rd_en,
  input  logic [PSEL_W-1:0]          rd_port,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data,
  output logic [$clog2(DATA_W/8)-1:0] rd_lane,
  output logic [$clog2(DATA_W/8+1)-1:0] rd_nbytes,
  output logic                       rd_sop,
  output logic                       rd_eop,
  output logic                       rd_no_pad_crc,
  output logic                       rd_force_err,
  output logic                       rd_prev_abort,
  output logic [(1<<PSEL_W)-1:0]     fifo_empty,
  output logic [(1<<PSEL_W)-1:0]     fifo_full,
  output logic [(1<<PSEL_W)-1:0]     proto_err,
  output logic [(1<<PSEL_W)-1:0]     overflow
);

  localparam int NPORT  = 1 << PSEL_W;
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int NB_W   = $clog2(LANES + 1);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int TAG_W  = $bits(txw_tag_t);
  localparam int ENT_W  = DATA_W + LANE_W + NB_W + TAG_W;
  localparam int ADDR_W = PSEL_W + PTR_W;
  localparam int HALF   = DATA_W / 2;

  logic              legal;
  logic [LANE_W-1:0] first_lane;
  logic [NB_W-1:0]   nbytes;

  logic [NPORT-1:0]  accept_v;
  logic [NPORT-1:0]  abort_v;
  logic [NPORT-1:0]  raw_v;
  logic [PTR_W-1:0]  wptr_a [NPORT];
  logic [PTR_W-1:0]  rptr_a [NPORT];

  logic              we;
  logic              re;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] data_in;
  txw_tag_t          tag_in;
  txw_tag_t          tag_out;
  logic [ENT_W-1:0]  wdata;
  logic [ENT_W-1:0]  rdata;
  logic              rd_valid_q;

  txw_be_check #(
    .LANES (LANES),
    .LANE_W(LANE_W),
    .NB_W  (NB_W)
  ) u_be (
    .be_n      (wr_be_n),
    .narrow    (narrow_mode),
    .legal     (legal),
    .first_lane(first_lane),
    .nbytes    (nbytes)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    txw_port_ctrl #(
      .DEPTH(DEPTH),
      .PTR_W(PTR_W),
      .CNT_W(CNT_W)
    ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .wr_hit   (!wr_sel_n && (wr_port == PSEL_W'(g))),
      .rd_hit   (rd_en && (rd_port == PSEL_W'(g))),
      .legal    (legal),
      .sop      (wr_sop),
      .eop      (wr_eop),
      .flag     (wr_flag),
      .accept   (accept_v[g]),
      .abort_tag(abort_v[g]),
      .raw_tag  (raw_v[g]),
      .wptr     (wptr_a[g]),
      .rptr     (rptr_a[g]),
      .empty    (fifo_empty[g]),
      .full     (fifo_full[g]),
      .proto_err(proto_err[g]),
      .overflow (overflow[g])
    );
  end

  always_comb begin
    data_in = narrow_mode ? {{(DATA_W - HALF){1'b0}}, wr_data[HALF-1:0]} : wr_data;
    tag_in.sop        = wr_sop;
    tag_in.eop        = wr_eop;
    tag_in.no_pad_crc = raw_v[wr_port];
    tag_in.force_err  = wr_eop && wr_flag;
    tag_in.prev_abort = abort_v[wr_port];
  end

  assign we    = |accept_v;
  assign waddr = {wr_port, wptr_a[wr_port]};
  assign wdata = {data_in, first_lane, nbytes, tag_in};
  assign re    = rd_en && !fifo_empty[rd_port];
  assign raddr = {rd_port, rptr_a[rd_port]};

  txw_store #(
    .ADDR_W(ADDR_W),
    .W     (ENT_W)
  ) u_store (
    .clk  (clk),
    .we   (we),
    .waddr(waddr),
    .wdata(wdata),
    .re   (re),
    .raddr(raddr),
    .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid_q <= 1'b0;
    else     rd_valid_q <= re;
  end

  assign {rd_data, rd_lane, rd_nbytes, tag_out} = rdata;
  assign rd_valid      = rd_valid_q;
  assign rd_sop        = tag_out.sop;
  assign rd_eop        = tag_out.eop;
  assign rd_no_pad_crc = tag_out.no_pad_crc;
  assign rd_force_err  = tag_out.force_err;
  assign rd_prev_abort = tag_out.prev_abort;

endmodule

// File: rtl/txw_chk.sv
module txw_chk #(
  parameter int PSEL_W = 3,
  parameter int NB_W   = 4,
  parameter int LANE_W = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_sel_n,
  input logic [PSEL_W-1:0]        wr_port,
  input logic                     rd_en,
  input logic [PSEL_W-1:0]        rd_port,
  input logic                     rd_valid,
  input logic [LANE_W-1:0]        rd_lane,
  input logic [NB_W-1:0]          rd_nbytes,
  input logic [(1<<PSEL_W)-1:0]   fifo_empty,
  input logic [(1<<PSEL_W)-1:0]   fifo_full,
  input logic [(1<<PSEL_W)-1:0]   proto_err,
  input logic [(1<<PSEL_W)-1:0]   overflow
);

  localparam int LANES = 1 << LANE_W;

  // R1
  idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sel_n && !rd_en) |=> ($stable(fifo_empty) && $stable(fifo_full)));

  // R10
  read_source_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && !fifo_empty[rd_port]));

  // R3
  lane_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_nbytes != '0 && (int'(rd_lane) + int'(rd_nbytes)) <= LANES));

  // R3
  proto_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((proto_err & $past(proto_err)) == $past(proto_err)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((overflow & $past(overflow)) == $past(overflow)));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_sel_n && fifo_full[wr_port]) |=>
      (overflow[$past(wr_port)] || proto_err[$past(wr_port)]));

  // R12
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ((fifo_empty & fifo_full) == '0));

endmodule

bind txpkt_fifo_writer txw_chk #(
  .PSEL_W(PSEL_W),
  .NB_W  (NB_W),
  .LANE_W(LANE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_sel_n  (wr_sel_n),
  .wr_port   (wr_port),
  .rd_en     (rd_en),
  .rd_port   (rd_port),
  .rd_valid  (rd_valid),
  .rd_lane   (rd_lane),
  .rd_nbytes (rd_nbytes),
  .fifo_empty(fifo_empty),
  .fifo_full (fifo_full),
  .proto_err (proto_err),
  .overflow  (overflow)
);

// File: tb/txpkt_fifo_writer_tb.sv
module txpkt_fifo_writer_tb;

  localparam int PERIOD = 10;

  typedef struct packed {
    logic [63:0] data;
    logic [2:0]  lane;
    logic [3:0]  nb;
    logic        sop;
    logic        eop;
    logic        raw;
    logic        err;
    logic        abt;
  } ent_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_sel_n = 1;
  logic [2:0]  wr_port = 0;
  logic [63:0] wr_data = 0;
  logic [7:0]  wr_be_n = 8'hFF;
  logic        wr_sop = 0, wr_eop = 0, wr_flag = 0, narrow_mode = 0;
  logic        rd_en = 0;
  logic [2:0]  rd_port = 0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [2:0]  rd_lane;
  logic [3:0]  rd_nbytes;
  logic        rd_sop, rd_eop, rd_no_pad_crc, rd_force_err, rd_prev_abort;
  logic [7:0]  fifo_empty, fifo_full, proto_err, overflow;

  int total = 0;
  int fails = 0;
  bit done = 0;

  ent_t q [8][$];
  bit   open_m [8];
  bit   raw_m [8];
  logic [7:0] e_proto, e_ovf;
  bit   e_valid;
  ent_t e_ent;

  always #(PERIOD/2) clk = ~clk;

  txpkt_fifo_writer u_dut (
    .clk(clk), .rst(rst), .wr_sel_n(wr_sel_n), .wr_port(wr_port),
    .wr_data(wr_data), .wr_be_n(wr_be_n), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .wr_flag(wr_flag), .narrow_mode(narrow_mode), .rd_en(rd_en),
    .rd_port(rd_port), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_lane(rd_lane), .rd_nbytes(rd_nbytes), .rd_sop(rd_sop),
    .rd_eop(rd_eop), .rd_no_pad_crc(rd_no_pad_crc),
    .rd_force_err(rd_force_err), .rd_prev_abort(rd_prev_abort),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .proto_err(proto_err), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated on each rising edge from the inputs
  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 8; p++) begin
        q[p].delete();
        open_m[p] = 0;
        raw_m[p]  = 0;
      end
      e_proto = 0;
      e_ovf   = 0;
      e_valid = 0;
    end else begin
      int sz0;
      sz0 = q[wr_port].size();
      e_valid = 0;
      if (rd_en && q[rd_port].size() > 0) begin
        e_valid = 1;
        e_ent   = q[rd_port].pop_front();
      end
      if (!wr_sel_n) begin
        logic [7:0] act_be;
        int n, runs, lo;
        act_be = ~wr_be_n & (narrow_mode ? 8'h0F : 8'hFF);
        n = 0; runs = 0; lo = -1;
        for (int i = 0; i < 8; i++) begin
          if (act_be[i]) begin
            n++;
            if (lo < 0) lo = i;
            if (i == 0 || !act_be[i-1]) runs++;
          end
        end
        if (n == 0 || runs != 1 || (!wr_sop && !open_m[wr_port])) begin
          e_proto[wr_port] = 1;
        end else if (sz0 >= 16) begin
          e_ovf[wr_port] = 1;
        end else begin
          ent_t e;
          e.data = narrow_mode ? {32'h0, wr_data[31:0]} : wr_data;
          e.lane = 3'(lo);
          e.nb   = 4'(n);
          e.sop  = wr_sop;
          e.eop  = wr_eop;
          e.raw  = wr_sop ? wr_flag : raw_m[wr_port];
          e.err  = wr_eop && wr_flag;
          e.abt  = wr_sop && open_m[wr_port];
          if (wr_sop) raw_m[wr_port] = wr_flag;
          open_m[wr_port] = !wr_eop;
          q[wr_port].push_back(e);
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [7:0] ee, ef;
      for (int p = 0; p < 8; p++) begin
        ee[p] = (q[p].size() == 0);
        ef[p] = (q[p].size() == 16);
      end
      chk("R10 rd_valid", 64'(rd_valid), 64'(e_valid));
      if (e_valid) begin
        chk("R2 rd_data", rd_data, e_ent.data);
        chk("R3 rd_lane", 64'(rd_lane), 64'(e_ent.lane));
        chk("R3 rd_nbytes", 64'(rd_nbytes), 64'(e_ent.nb));
        chk("R2 rd_sop/eop", 64'({rd_sop, rd_eop}), 64'({e_ent.sop, e_ent.eop}));
        chk("R4 rd_no_pad_crc", 64'(rd_no_pad_crc), 64'(e_ent.raw));
        chk("R5 rd_force_err", 64'(rd_force_err), 64'(e_ent.err));
        chk("R6 rd_prev_abort", 64'(rd_prev_abort), 64'(e_ent.abt));
      end
      chk("R12 fifo_empty", 64'(fifo_empty), 64'(ee));
      chk("R12 fifo_full", 64'(fifo_full), 64'(ef));
      chk("R3 R7 proto_err", 64'(proto_err), 64'(e_proto));
      chk("R8 overflow", 64'(overflow), 64'(e_ovf));
    end
  end

  task automatic cyc(input bit w, input int port, input logic [63:0] d,
                     input logic [7:0] ben, input bit s, input bit e, input bit f,
                     input bit nar, input bit r, input int rport);
    @(negedge clk);
    wr_sel_n = !w; wr_port = 3'(port); wr_data = d; wr_be_n = ben;
    wr_sop = s; wr_eop = e; wr_flag = f; narrow_mode = nar;
    rd_en = r; rd_port = 3'(rport);
  endtask

  task automatic wr(input int port, input logic [63:0] d, input logic [7:0] ben,
                    input bit s, input bit e, input bit f);
    cyc(1, port, d, ben, s, e, f, 0, 0, 0);
  endtask

  task automatic idle();
    cyc(0, 0, 64'h0, 8'hFF, 0, 0, 0, 0, 0, 0);
  endtask

  // request one read; outputs are valid when the task returns
  task automatic rd1(input int port);
    cyc(0, 0, 64'h0, 8'hFF, 0, 0, 0, 0, 1, port);
    idle();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    idle();
    // R11 reset state
    chk("R11 empty", 64'(fifo_empty), 64'hFF);
    chk("R11 full", 64'(fifo_full), 64'h0);
    chk("R11 flags", 64'({proto_err, overflow}), 64'h0);
    chk("R11 rd_valid", 64'(rd_valid), 64'h0);

    // R1 select high
    for (int i = 0; i < 3; i++)
      cyc(0, 0, 64'h1111, 8'h00, 1, 1, 0, 0, 0, 0);
    idle();
    chk("R1 no write", 64'(fifo_empty), 64'hFF);

    // R4 / R2 packet on port 2 with skip flag at start
    wr(2, 64'hA0, 8'h00, 1, 0, 1);
    wr(5, 64'hB0, 8'h00, 1, 0, 0);
    wr(2, 64'hA1, 8'h00, 0, 0, 0);
    wr(5, 64'hB1, 8'hF0, 0, 1, 1);
    wr(2, 64'hA2, 8'hFE, 0, 1, 0);
    idle();
    rd1(2);
    chk("R2 first data", rd_data, 64'hA0);
    chk("R4 raw first", 64'(rd_no_pad_crc), 64'h1);
    rd1(2); rd1(2);
    chk("R4 raw last", 64'(rd_no_pad_crc), 64'h1);
    chk("R5 no err when flag low", 64'(rd_force_err), 64'h0);
    rd1(5);
    chk("R5 err not on first", 64'(rd_force_err), 64'h0);
    rd1(5);
    chk("R5 err on last", 64'(rd_force_err), 64'h1);
    chk("R3 nbytes low half", 64'(rd_nbytes), 64'h4);

    // R3 illegal enables
    wr(1, 64'h0, 8'hFF, 1, 1, 0);
    wr(4, 64'h0, 8'b1111_1010, 1, 1, 0);
    idle();
    chk("R3 proto set", 64'({proto_err[1], proto_err[4]}), 64'h3);
    chk("R3 not stored", 64'({fifo_empty[1], fifo_empty[4]}), 64'h3);
    wr(6, 64'hC0, 8'b1110_0011, 1, 1, 0);
    idle();
    rd1(6);
    chk("R3 lane", 64'(rd_lane), 64'h2);
    chk("R3 count", 64'(rd_nbytes), 64'h3);

    // R7 orphan word
    wr(7, 64'hD0, 8'h00, 0, 0, 0);
    idle();
    chk("R7 orphan proto", 64'(proto_err[7]), 64'h1);
    chk("R7 orphan dropped", 64'(fifo_empty[7]), 64'h1);

    // R6 restart mid packet
    wr(0, 64'hE0, 8'h00, 1, 0, 0);
    wr(0, 64'hE1, 8'h00, 0, 0, 0);
    wr(0, 64'hE2, 8'h00, 1, 1, 0);
    idle();
    rd1(0);
    chk("R6 first no abort", 64'(rd_prev_abort), 64'h0);
    rd1(0); rd1(0);
    chk("R6 abort tag", 64'({rd_prev_abort, rd_sop}), 64'h3);

    // R8 fill port 3
    wr(3, 64'h300, 8'h00, 1, 0, 0);
    for (int i = 1; i < 16; i++) wr(3, 64'(32'h300 + i), 8'h00, 0, 0, 0);
    idle();
    chk("R12 full", 64'(fifo_full[3]), 64'h1);
    chk("R8 no ovf yet", 64'(overflow[3]), 64'h0);
    cyc(1, 3, 64'h3FF, 8'h00, 0, 0, 0, 0, 1, 3);
    idle();
    chk("R8 ovf set", 64'(overflow[3]), 64'h1);

    // R9 narrow mode
    cyc(1, 1, 64'hDEADBEEF_12345678, 8'h00, 1, 1, 0, 1, 0, 0);
    idle();
    rd1(1);
    chk("R9 upper zero", rd_data, 64'h12345678);
    chk("R9 four bytes", 64'(rd_nbytes), 64'h4);

    // R10 read of empty port
    rd1(4);
    chk("R10 empty read", 64'(rd_valid), 64'h0);

    // randomized traffic
    for (int i = 0; i < 3000; i++) begin
      int lo, n;
      logic [7:0] ben;
      lo = $urandom % 8;
      n  = 1 + ($urandom % (8 - lo));
      ben = ~(8'((1 << n) - 1) << lo);
      if ($urandom % 10 == 0) ben = 8'($urandom);
      cyc(($urandom % 4) != 0, $urandom % 8, {$urandom, $urandom}, ben,
          ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
          ($urandom % 8) == 0, ($urandom % 2) == 0, $urandom % 8);
    end
    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 17; k++) cyc(0, 0, 64'h0, 8'hFF, 0, 0, 0, 0, 1, p);
    idle();
    idle();
    chk("R10 drained", 64'(fifo_empty), 64'hFF);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule